// File: doc/BRIEF.md
# MSI Capability Register File and Interrupt Message Generator

This block sits on the device side of a PCI Express function. It holds the message signaled interrupt capability in a small window of configuration space that software reads and writes one dword at a time. It turns single-cycle interrupt events into memory-write requests that carry the address and data software programmed. Requests leave on a valid/ready pair, and a separate module formats them into packets. When the capability is enabled, an output tells the legacy wire interrupt logic to stay quiet.

The vector count the block supports, the 64-bit address option and the per-vector masking option are elaboration parameters. Software may enable fewer vectors than supported. Events on vectors that are not enabled fold onto the highest enabled vector. A masked vector sends nothing and records a pending bit. The message goes out once software clears the mask.

Top module: `msi_msg_gen`

## Requirements
- R1: After reset the dword at offset 0x00 reads {control[15:0], next pointer[7:0], 8'h05}. The control bits are: bit 0 enable, bits 3:1 supported-vector log2 (parameter `MMC`), bits 6:4 enabled-vector log2, bit 7 64-bit capable, bit 8 masking capable. Enable and the enabled log2 reset to 0. A read strobe returns its data on `cfg_rdata` at the following clock edge.
- R2: A write to offset 0x00 updates only enable (write bit 16) and the enabled log2 (write bits 22:20). An enabled log2 written above `MMC` is stored as `MMC`. Bits 3:1, 7 and 8 are read-only.
- R3: `intx_disable` is high exactly while the enable bit is set.
- R4: A message carries the address {upper, low} with low bits 1:0 forced to 0. Its data is the programmed 16-bit data with its low MME bits replaced by the vector number, where MME is the enabled log2.
- R5: An event on vector i with i > 2^MME-1 is sent as vector 2^MME-1.
- R6: While enable is clear, events are dropped. No message starts and no pending bit is recorded.
- R7: With masking capable, an event on a vector whose mask bit is set sends no message. The pending bit of that vector reads 1 (64-bit layout: mask at 0x10, pending at 0x14, bit i = vector i).
- R8: Clearing a mask bit whose pending bit is set sends that vector's message and clears the pending bit.
- R9: Events that arrive together are sent one message at a time, lowest vector first.
- R10: `msg_valid` remains high, with address and data unchanged, until `msg_ready` is seen high.
- R11: Without 64-bit capability there is no upper-address register, the upper half of `msg_addr` is 0, and data, mask and pending sit at 0x08, 0x0C and 0x10. Without masking capability the mask and pending registers read 0 and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_addr | input | 8 | Dword-aligned byte offset within the capability |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, registered |
| evt | input | 2^MMC | Single-cycle interrupt event pulses, one per vector |
| intx_disable | output | 1 | Tells the legacy interrupt logic to stay silent |
| msg_valid | output | 1 | Memory-write request valid |
| msg_ready | input | 1 | Consumer accepts the request |
| msg_addr | output | 64 | Request address |
| msg_data | output | 16 | Request data |

## Verification
The bench walks folding at several enabled-vector widths. A design that did not clamp the vector index would send an index that the data field cannot hold, and the low data bits would then be wrong. It programs an over-range enabled count, which a missing clamp would read back unchanged. It sends events while the block is disabled and checks that no pending bit appears, then masks a vector, checks its pending bit, and unmasks it. A design that dropped the pending event would never send it, and one that failed to clear the pending bit would leave it readable afterwards. Three events arrive together under backpressure, so wrong priority shows as an out-of-order vector, and wrong hold behaviour shows as data changing while the consumer is stalled. A second instance built without 64-bit addressing and without masking checks the shifted offsets and the inert mask.

// File: rtl/msi_pkg.sv
package msi_pkg;
  localparam logic [7:0] CAP_ID   = 8'h05;
  localparam logic [7:0] OFF_CTRL = 8'h00;
  localparam logic [7:0] OFF_ALO  = 8'h04;
  localparam logic [7:0] OFF_AHI  = 8'h08;

  // data, mask and pending move down one dword when there is no upper address
  function automatic logic [7:0] off_data(input bit a64);
    return a64 ? 8'h0C : 8'h08;
  endfunction
  function automatic logic [7:0] off_mask(input bit a64);
    return a64 ? 8'h10 : 8'h0C;
  endfunction
  function automatic logic [7:0] off_pend(input bit a64);
    return a64 ? 8'h14 : 8'h10;
  endfunction
endpackage

// File: rtl/msi_cfg_regs.sv
module msi_cfg_regs
  import msi_pkg::*;
#(
  parameter int MMC      = 5,
  parameter int ADDR64   = 1,
  parameter int PVM      = 1,
  parameter int NEXT_PTR = 0,
  parameter int NV       = 1 << MMC
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_wr,
  input  logic          cfg_rd,
  input  logic [7:0]    cfg_addr,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata,
  input  logic [NV-1:0] flag_in,
  output logic          en,
  output logic [2:0]    mme,
  output logic [63:0]   addr,
  output logic [15:0]   data,
  output logic [NV-1:0] mask
);
  localparam bit         A64    = (ADDR64 != 0);
  localparam bit         MSK    = (PVM != 0);
  localparam logic [7:0] O_DATA = off_data(A64);
  localparam logic [7:0] O_MASK = off_mask(A64);
  localparam logic [7:0] O_PEND = off_pend(A64);
  localparam logic [2:0] MMC3   = 3'(MMC);

  logic [31:0] alo_q, ahi_q;
  logic [31:0] rd_mux, mtmp, ptmp;
  logic [15:0] ctrl;
  logic [2:0]  mme_w;
  logic        unused_bits;

  assign unused_bits = ^{alo_q[1:0], cfg_wdata};
  assign mme_w = (cfg_wdata[22:20] > MMC3) ? MMC3 : cfg_wdata[22:20];
  assign ctrl  = {7'b0, MSK, A64, mme, MMC3, en};
  assign addr  = {A64 ? ahi_q : 32'h0, alo_q[31:2], 2'b00};

  always_comb begin
    mtmp = '0;
    ptmp = '0;
    mtmp[NV-1:0] = mask;
    ptmp[NV-1:0] = flag_in & mask;
    rd_mux = '0;
    if (cfg_addr == OFF_CTRL)              rd_mux = {ctrl, 8'(NEXT_PTR), CAP_ID};
    else if (cfg_addr == OFF_ALO)          rd_mux = {alo_q[31:2], 2'b00};
    else if (A64 && cfg_addr == OFF_AHI)   rd_mux = ahi_q;
    else if (cfg_addr == O_DATA)           rd_mux = {16'h0, data};
    else if (cfg_addr == O_MASK)           rd_mux = mtmp;
    else if (cfg_addr == O_PEND)           rd_mux = ptmp;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en        <= 1'b0;
      mme       <= 3'd0;
      alo_q     <= '0;
      ahi_q     <= '0;
      data      <= '0;
      mask      <= '0;
      cfg_rdata <= '0;
    end else begin
      if (cfg_wr) begin
        if (cfg_addr == OFF_CTRL) begin
          en  <= cfg_wdata[16];
          mme <= mme_w;
        end
        if (cfg_addr == OFF_ALO)                alo_q <= cfg_wdata;
        if (A64 && cfg_addr == OFF_AHI)         ahi_q <= cfg_wdata;
        if (cfg_addr == O_DATA)                 data  <= cfg_wdata[15:0];
        if (MSK && cfg_addr == O_MASK)          mask  <= cfg_wdata[NV-1:0];
      end
      if (cfg_rd) cfg_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/msi_vec_arb.sv
module msi_vec_arb #(
  parameter int NV = 32,
  parameter int VW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [2:0]    mme,
  input  logic [NV-1:0] evt,
  input  logic [NV-1:0] mask,
  input  logic          take,
  output logic [NV-1:0] flag,
  output logic          pick_valid,
  output logic [VW-1:0] pick_idx
);
  logic [NV-1:0] set, clr, elig;
  int            topi, tgt;

  // fold events above the enabled range onto the top enabled vector
  always_comb begin
    set  = '0;
    topi = (1 << mme) - 1;
    tgt  = 0;
    if (en) begin
      for (int i = 0; i < NV; i++) begin
        if (evt[i]) begin
          tgt = (i > topi) ? topi : i;
          set[tgt] = 1'b1;
        end
      end
    end
  end

  always_comb begin
    clr = '0;
    if (take) clr[pick_idx] = 1'b1;
  end

  assign elig = flag & ~mask;

  // lowest eligible vector wins
  always_comb begin
    pick_valid = 1'b0;
    pick_idx   = '0;
    for (int i = NV - 1; i >= 0; i--) begin
      if (elig[i]) begin
        pick_valid = 1'b1;
        pick_idx   = VW'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) flag <= '0;
    else     flag <= (flag & ~clr) | set;
  end
endmodule

// File: rtl/msi_msg_out.sv
module msi_msg_out #(
  parameter int VW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          pick_valid,
  input  logic [VW-1:0] pick_idx,
  input  logic [2:0]    mme,
  input  logic [63:0]   addr,
  input  logic [15:0]   data,
  input  logic          msg_ready,
  output logic          msg_valid,
  output logic [63:0]   msg_addr,
  output logic [15:0]   msg_data,
  output logic          take
);
  logic [15:0] lowmask, data_n;

  assign lowmask = 16'((32'd1 << mme) - 32'd1);
  assign data_n  = (data & ~lowmask) | (16'(pick_idx) & lowmask);
  assign take    = en && pick_valid && (!msg_valid || msg_ready);

  always_ff @(posedge clk) begin
    if (rst) begin
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else if (take) begin
      msg_valid <= 1'b1;
      msg_addr  <= addr;
      msg_data  <= data_n;
    end else if (msg_ready) begin
      msg_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/msi_msg_gen.sv
module msi_msg_gen #(
  parameter int MMC      = 5,
  parameter int ADDR64   = 1,
  parameter int PVM      = 1,
  parameter int NEXT_PTR = 0,
  parameter int NV       = 1 << MMC
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_wr,
  input  logic          cfg_rd,
  input  logic [7:0]    cfg_addr,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata,
  input  logic [NV-1:0] evt,
  output logic          intx_disable,
  output logic          msg_valid,
  input  logic          msg_ready,
  output logic [63:0]   msg_addr,
  output logic [15:0]   msg_data
);
  localparam int VW = (MMC == 0) ? 1 : MMC;

  logic          en, take, pick_valid;
  logic [2:0]    mme;
  logic [63:0]   reg_addr;
  logic [15:0]   reg_data;
  logic [NV-1:0] mask, flag;
  logic [VW-1:0] pick_idx;

  assign intx_disable = en;

  msi_cfg_regs #(.MMC(MMC), .ADDR64(ADDR64), .PVM(PVM), .NEXT_PTR(NEXT_PTR), .NV(NV)) u_regs (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .flag_in(flag), .en(en), .mme(mme),
    .addr(reg_addr), .data(reg_data), .mask(mask)
  );

  msi_vec_arb #(.NV(NV), .VW(VW)) u_arb (
    .clk(clk), .rst(rst), .en(en), .mme(mme), .evt(evt), .mask(mask), .take(take),
    .flag(flag), .pick_valid(pick_valid), .pick_idx(pick_idx)
  );

  msi_msg_out #(.VW(VW)) u_out (
    .clk(clk), .rst(rst), .en(en), .pick_valid(pick_valid), .pick_idx(pick_idx),
    .mme(mme), .addr(reg_addr), .data(reg_data), .msg_ready(msg_ready),
    .msg_valid(msg_valid), .msg_addr(msg_addr), .msg_data(msg_data), .take(take)
  );
endmodule

// File: rtl/msi_msg_gen_chk.sv
module msi_msg_gen_chk (
  input logic        clk,
  input logic        rst,
  input logic        cfg_wr,
  input logic        cfg_rd,
  input logic [7:0]  cfg_addr,
  input logic [31:0] cfg_wdata,
  input logic [31:0] cfg_rdata,
  input logic        intx_disable,
  input logic        msg_valid,
  input logic        msg_ready,
  input logic [63:0] msg_addr,
  input logic [15:0] msg_data,
  input logic [63:0] reg_addr
);
  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

  assert_intx_rise_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(intx_disable) |-> $past(cfg_wr && cfg_addr == 8'h00 && cfg_wdata[16]));

  assert_no_start_R6: assert property (@(posedge clk) disable iff (rst)
    (!intx_disable && !msg_valid) |=> !msg_valid);

  assert_addr_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(msg_valid) |-> (msg_addr == $past(reg_addr)));

  assert_capid_R1: assert property (@(posedge clk) disable iff (rst)
    (cfg_rd && cfg_addr == 8'h00) |=> (cfg_rdata[7:0] == 8'h05));
endmodule

bind msi_msg_gen msi_msg_gen_chk u_chk (
  .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .intx_disable(intx_disable),
  .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr),
  .msg_data(msg_data), .reg_addr(reg_addr)
);

// File: tb/sim_msi_msg_gen.sv
module sim_msi_msg_gen;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic        sel = 1'b0;
  logic        wr = 1'b0, rd = 1'b0, rdy = 1'b1;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] evt = '0;

  logic [31:0] rdata0, rdata1;
  logic        intx0, intx1, val0, val1;
  logic [63:0] maddr0, maddr1;
  logic [15:0] mdata0, mdata1;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  msi_msg_gen u0 (
    .clk(clk), .rst(rst), .cfg_wr(wr && !sel), .cfg_rd(rd && !sel), .cfg_addr(addr),
    .cfg_wdata(wdata), .cfg_rdata(rdata0), .evt(sel ? 32'h0 : evt),
    .intx_disable(intx0), .msg_valid(val0), .msg_ready(rdy),
    .msg_addr(maddr0), .msg_data(mdata0)
  );

  msi_msg_gen #(.MMC(2), .ADDR64(0), .PVM(0), .NEXT_PTR(8'h40)) u1 (
    .clk(clk), .rst(rst), .cfg_wr(wr && sel), .cfg_rd(rd && sel), .cfg_addr(addr),
    .cfg_wdata(wdata), .cfg_rdata(rdata1), .evt(sel ? evt[3:0] : 4'h0),
    .intx_disable(intx1), .msg_valid(val1), .msg_ready(rdy),
    .msg_addr(maddr1), .msg_data(mdata1)
  );

  wire        cur_val  = sel ? val1 : val0;
  wire [63:0] cur_addr = sel ? maddr1 : maddr0;
  wire [15:0] cur_data = sel ? mdata1 : mdata0;

  // mme, event index, expected vector
  localparam int TV [8][3] = '{
    '{0, 7, 0}, '{1, 0, 0}, '{1, 3, 1}, '{2, 2, 2},
    '{3, 9, 7}, '{5, 31, 31}, '{5, 17, 17}, '{4, 20, 15}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic cfg_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0;
    d = sel ? rdata1 : rdata0;
  endtask

  task automatic pulse(input logic [31:0] v);
    @(negedge clk); evt = v;
    @(negedge clk); evt = '0;
  endtask

  task automatic wait_msg(input int lim, output bit got);
    got = 1'b0;
    for (int k = 0; k < lim; k++) begin
      if (cur_val) begin got = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R10 watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    bit          got;
    logic [15:0] lm;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // reset state
    cfg_read(8'h00, r);  check("R1 header after reset", r, 32'h018A_0005);
    check("R3 intx low after reset", intx0, 1'b0);
    check("R10 no request after reset", val0, 1'b0);
    cfg_read(8'h14, r);  check("R7 pending clear after reset", r, 0);

    // clamp of enabled count
    cfg_write(8'h00, 32'h0071_0000 | 32'h00EE_0000);
    cfg_read(8'h00, r);  check("R2 mme clamp, ro bits kept", r, 32'h01DB_0005);
    check("R3 intx high when enabled", intx0, 1'b1);

    cfg_write(8'h04, 32'hFEE0_3003);
    cfg_write(8'h08, 32'h0000_0001);
    cfg_write(8'h0C, 32'h0000_4A7F);
    cfg_write(8'h10, 32'h0);
    cfg_read(8'h04, r);  check("R4 low address low bits read 0", r, 32'hFEE0_3000);

    // table walk: folding and data substitution
    for (int t = 0; t < 8; t++) begin
      cfg_write(8'h00, 32'h0001_0000 | (32'(TV[t][0]) << 20));
      pulse(32'h1 << TV[t][1]);
      wait_msg(8, got);
      lm = 16'((1 << TV[t][0]) - 1);
      check($sformatf("R5 fold entry %0d seen", t), got, 1'b1);
      check($sformatf("R4 data entry %0d", t), cur_data, (16'h4A7F & ~lm) | (16'(TV[t][2]) & lm));
      check($sformatf("R4 address entry %0d", t), cur_addr, 64'h0000_0001_FEE0_3000);
      @(negedge clk);
    end

    // disabled: ignored and nothing pending
    cfg_write(8'h00, 32'h0050_0000);
    check("R3 intx low when disabled", intx0, 1'b0);
    cfg_write(8'h10, 32'h0000_0008);
    pulse(32'h0000_0018);
    wait_msg(8, got);    check("R6 no message while disabled", got, 1'b0);
    cfg_read(8'h14, r);  check("R6 no pending while disabled", r, 0);

    // masked vector records pending
    cfg_write(8'h00, 32'h0051_0000);
    pulse(32'h0000_0008);
    wait_msg(8, got);    check("R7 masked vector silent", got, 1'b0);
    cfg_read(8'h14, r);  check("R7 pending bit set", r, 32'h0000_0008);

    // unmask releases it
    cfg_write(8'h10, 32'h0);
    wait_msg(8, got);    check("R8 released on unmask", got, 1'b1);
    check("R8 released vector", cur_data, 16'h4A63);
    @(negedge clk);
    cfg_read(8'h14, r);  check("R8 pending cleared", r, 0);

    // simultaneous events under backpressure
    rdy = 1'b0;
    pulse(32'h0010_0204);
    wait_msg(8, got);    check("R9 first request appears", got, 1'b1);
    check("R9 lowest vector first", cur_data, 16'h4A62);
    repeat (3) @(negedge clk);
    check("R10 held under stall", val0, 1'b1);
    check("R10 data stable under stall", mdata0, 16'h4A62);
    rdy = 1'b1;
    @(negedge clk);      check("R9 second vector", mdata0, 16'h4A69);
    @(negedge clk);      check("R9 third vector", mdata0, 16'h4A74);
    @(negedge clk);      check("R10 valid drops when drained", val0, 1'b0);

    // second instance: 32-bit layout, no masking
    sel = 1'b1;
    cfg_read(8'h00, r);  check("R1 header of reduced instance", r, 32'h0004_4005);
    cfg_write(8'h08, 32'h0000_1234);
    cfg_read(8'h08, r);  check("R11 data at shifted offset", r, 32'h0000_1234);
    cfg_write(8'h0C, 32'h0000_000F);
    cfg_read(8'h0C, r);  check("R11 mask reads 0 without masking", r, 0);
    cfg_write(8'h04, 32'hFEE0_0000);
    cfg_write(8'h00, 32'h0021_0000);
    pulse(32'h0000_0002);
    wait_msg(8, got);    check("R11 mask write has no effect", got, 1'b1);
    check("R11 upper address zero", cur_addr, 64'h0000_0000_FEE0_0000);
    check("R11 data vector", cur_data, 16'h1235);
    @(negedge clk);
    cfg_read(8'h10, r);  check("R11 pending reads 0", r, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule